// File: doc/BRIEF.md
# Command stream header decoder

This block sits on a 32-bit command stream and takes one word per cycle under a valid/ready handshake. The first word it sees after reset is a header. The header's top four bits select an operation, and the other fields say how many payload words follow it. Each payload word is matched to the header that came before it. When the last payload word has been taken, the next word is read as a new header.

Payload words of the write-type operations come out as register-write requests. Each request carries the active class, a register offset and the data word. The offset is stepped in a way that depends on the operation: it can increase by one per word, stay fixed, or follow the set bits of a mask from the lowest to the highest.

Jump, fetch and extended operations do not produce register writes. They raise one-cycle side pulses, together with their decoded fields, for logic further down the chain. The write port is not buffered. A word that would produce a write is accepted only in a cycle where the write port is ready. Every other word is accepted at once.

Top module: `cmd_hdr_decoder`

## Requirements
- R1: The operation is taken from header bits 31:28: 0 set-class, 1 incrementing write, 2 non-incrementing write, 3 masked write, 4 immediate, 5 restart, 6 gather, 14 extend. Any other code is accepted as a header with no payload and produces no write and no side pulse. At most one of the write, restart, gather and extend outputs is valid in a cycle.
- R2: A set-class header loads the class from bits 15:6, and that class is used by all later writes. If its mask in bits 5:0 is nonzero, one payload word follows for each set bit. Each word goes to the offset in bits 27:16 plus the bit position, with the lowest set bit first. A zero mask means no payload.
- R3: An incrementing write header carries an offset in bits 27:16 and a word count in bits 15:0. Its payload words go to offset, offset+1, and so on.
- R4: A non-incrementing write header has the same fields as R3, but every payload word goes to the same offset.
- R5: A masked write header carries an offset in bits 27:16 and a 16-bit mask in bits 15:0. One payload word follows for each set bit, written to offset plus the bit position, lowest bit first. Offsets wrap modulo 4096.
- R6: An immediate header has no payload. It writes bits 15:0, zero-extended, to the offset in bits 27:16.
- R7: A restart header has no payload. It pulses `rst_valid`, with `rst_addr` equal to the header shifted left by four bits.
- R8: A gather header takes exactly one payload word. When that word is accepted, `gat_valid` pulses with the header's offset (bits 27:16), insert flag (bit 15), type (bit 14) and count (bits 13:0), and `gat_addr` equal to the payload word. No register write is made.
- R9: An extend header has no payload. It pulses `ext_valid` with `ext_kind` set to 0 when the sub-operation in bits 27:24 is 0 (acquire), 1 when it is 1 (release), and 2 for any other value. `ext_index` is bits 7:0.
- R10: The word after the last payload word is always decoded as a header. An incrementing or non-incrementing write with a count of zero goes straight back to header decoding.
- R11: A word that produces a register write is accepted only when `wr_ready` is high, and a stalled word changes no state. Every other word is accepted whenever it is valid.
- R12: After reset the block is in header decoding and the class is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word accepted |
| in_word | input | 32 | Command word |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Write sink can accept |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset |
| wr_data | output | 32 | Write data |
| rst_valid | output | 1 | Restart pulse |
| rst_addr | output | 32 | Restart target address |
| gat_valid | output | 1 | Gather pulse |
| gat_offset | output | 12 | Gather offset field |
| gat_insert | output | 1 | Gather insert flag |
| gat_type | output | 1 | Gather type bit |
| gat_count | output | 14 | Gather count |
| gat_addr | output | 32 | Gather fetch address |
| ext_valid | output | 1 | Extend pulse |
| ext_kind | output | 2 | 0 acquire, 1 release, 2 unknown |
| ext_index | output | 8 | Lock index |

## Verification
The bench aims at the following corner cases:
- Zero-count incrementing writes and zero-mask set-class headers. A decoder that wrongly waits for a payload here would treat the next header as data and send a write to the wrong place.
- Masks with sparse bits and masks whose offsets wrap past 4095. These expose any mistake in bit ordering or in the offset addition.
- An unknown opcode whose low bits look like a count. This catches a decoder that leaks a payload count across operations.
- Back-pressure on `wr_ready`, applied randomly and in directed cases. This shows whether a stalled word advances the offset or the count and so drops a write or repeats one.

// File: rtl/cmd_hdr_decoder.sv
module cmd_hdr_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [9:0]  wr_class,
  output logic [11:0] wr_offset,
  output logic [31:0] wr_data,
  output logic        rst_valid,
  output logic [31:0] rst_addr,
  output logic        gat_valid,
  output logic [11:0] gat_offset,
  output logic        gat_insert,
  output logic        gat_type,
  output logic [13:0] gat_count,
  output logic [31:0] gat_addr,
  output logic        ext_valid,
  output logic [1:0]  ext_kind,
  output logic [7:0]  ext_index
);
  localparam logic [3:0] OP_SETCL   = 4'h0;
  localparam logic [3:0] OP_INCR    = 4'h1;
  localparam logic [3:0] OP_NONINCR = 4'h2;
  localparam logic [3:0] OP_MASK    = 4'h3;
  localparam logic [3:0] OP_IMM     = 4'h4;
  localparam logic [3:0] OP_RESTART = 4'h5;
  localparam logic [3:0] OP_GATHER  = 4'h6;
  localparam logic [3:0] OP_EXTEND  = 4'he;

  function automatic logic [4:0] pop16(input logic [15:0] v);
    pop16 = '0;
    for (int i = 0; i < 16; i++) pop16 = pop16 + {4'b0, v[i]};
  endfunction

  function automatic logic [3:0] low16(input logic [15:0] v);
    low16 = '0;
    for (int i = 15; i >= 0; i--) if (v[i]) low16 = 4'(i);
  endfunction

  logic        in_pay;
  logic [15:0] rem;
  logic [3:0]  cop;
  logic [11:0] coff;
  logic [15:0] cmask;
  logic [9:0]  cls;

  logic [3:0]  hop;
  logic [15:0] hcnt;
  logic [15:0] hmask;
  logic        pay_wr, hdr_wr, acc;
  logic [11:0] pay_off;

  assign hop = in_word[31:28];

  always_comb begin
    hcnt  = '0;
    hmask = '0;
    case (hop)
      OP_SETCL:            begin hmask = {10'b0, in_word[5:0]}; hcnt = {11'b0, pop16(hmask)}; end
      OP_INCR, OP_NONINCR: hcnt = in_word[15:0];
      OP_MASK:             begin hmask = in_word[15:0]; hcnt = {11'b0, pop16(hmask)}; end
      OP_GATHER:           hcnt = 16'd1;
      default:             hcnt = '0;
    endcase
  end

  assign pay_wr   = in_pay && (cop != OP_GATHER);
  assign hdr_wr   = !in_pay && (hop == OP_IMM);
  assign in_ready = !(pay_wr || hdr_wr) || wr_ready;
  assign acc      = in_valid && in_ready;
  assign pay_off  = (cop == OP_INCR || cop == OP_NONINCR) ? coff : coff + {8'b0, low16(cmask)};

  assign wr_valid  = in_valid && (pay_wr || hdr_wr);
  assign wr_class  = cls;
  assign wr_offset = in_pay ? pay_off : in_word[27:16];
  assign wr_data   = in_pay ? in_word : {16'b0, in_word[15:0]};

  assign rst_valid = acc && !in_pay && (hop == OP_RESTART);
  assign rst_addr  = {in_word[27:0], 4'b0};

  assign gat_valid = acc && in_pay && (cop == OP_GATHER);
  assign gat_addr  = in_word;

  assign ext_valid = acc && !in_pay && (hop == OP_EXTEND);
  assign ext_kind  = (in_word[27:24] == 4'd0) ? 2'd0 : (in_word[27:24] == 4'd1) ? 2'd1 : 2'd2;
  assign ext_index = in_word[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pay     <= 1'b0;
      rem        <= '0;
      cop        <= '0;
      coff       <= '0;
      cmask      <= '0;
      cls        <= '0;
      gat_offset <= '0;
      gat_insert <= 1'b0;
      gat_type   <= 1'b0;
      gat_count  <= '0;
    end else if (acc) begin
      if (!in_pay) begin
        cop    <= hop;
        coff   <= in_word[27:16];
        cmask  <= hmask;
        rem    <= hcnt;
        in_pay <= (hcnt != 16'd0);
        if (hop == OP_SETCL) cls <= in_word[15:6];
        if (hop == OP_GATHER) begin
          gat_offset <= in_word[27:16];
          gat_insert <= in_word[15];
          gat_type   <= in_word[14];
          gat_count  <= in_word[13:0];
        end
      end else begin
        rem    <= rem - 16'd1;
        in_pay <= (rem != 16'd1);
        if (cop == OP_INCR) coff <= coff + 12'd1;
        cmask  <= cmask & (cmask - 16'd1);
      end
    end
  end

  p_one_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, rst_valid, gat_valid, ext_valid}));

  p_class_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_pay || hop != OP_SETCL)) |=> $stable(cls));

  p_incr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_pay && cop == OP_INCR && rem > 16'd1) |=> (coff == $past(coff) + 12'd1));

  p_pay_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_pay |-> (rem != 16'd0));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ($stable(rem) && $stable(in_pay) && $stable(coff) && $stable(cmask)));

  p_write_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> in_valid);
endmodule

// File: tb/cmd_hdr_decoder_bench.sv
module cmd_hdr_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic wr_ready = 1'b1;
  logic in_ready, wr_valid, rst_valid, gat_valid, gat_insert, gat_type, ext_valid;
  logic [9:0] wr_class;
  logic [11:0] wr_offset, gat_offset;
  logic [31:0] wr_data, rst_addr, gat_addr;
  logic [13:0] gat_count;
  logic [1:0] ext_kind;
  logic [7:0] ext_index;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_hdr_decoder u_cmd_hdr_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_class(wr_class), .wr_offset(wr_offset),
    .wr_data(wr_data), .rst_valid(rst_valid), .rst_addr(rst_addr), .gat_valid(gat_valid),
    .gat_offset(gat_offset), .gat_insert(gat_insert), .gat_type(gat_type),
    .gat_count(gat_count), .gat_addr(gat_addr), .ext_valid(ext_valid),
    .ext_kind(ext_kind), .ext_index(ext_index)
  );

  // bench reference state
  bit m_pay = 0;
  int m_rem = 0;
  logic [3:0] m_op = '0;
  logic [11:0] m_off = '0;
  logic [15:0] m_mask = '0;
  logic [9:0] m_cls = '0;
  logic [27:0] m_gat = '0;

  function automatic int lowest(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'h0: return "R2";
      4'h1: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      4'h6: return "R8";
      4'he: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic rdy, input string tag_in);
    logic iswr, e_rdy, e_rv, e_gv, e_xv;
    logic [11:0] e_off;
    logic [31:0] e_data;
    logic [1:0] e_kind;
    logic [191:0] av, ev;
    string tag;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; wr_ready = rdy;
    #2;
    e_rv = 0; e_gv = 0; e_xv = 0; e_off = '0; e_data = '0;
    if (m_pay) begin
      iswr = (m_op != 4'h6);
      e_off = (m_op == 4'h1 || m_op == 4'h2) ? m_off : m_off + 12'(lowest(m_mask));
      e_data = w;
    end else begin
      iswr = (w[31:28] == 4'h4);
      e_off = w[27:16];
      e_data = {16'b0, w[15:0]};
    end
    e_rdy = !iswr || rdy;
    if (e_rdy) begin
      e_rv = !m_pay && w[31:28] == 4'h5;
      e_gv = m_pay && m_op == 4'h6;
      e_xv = !m_pay && w[31:28] == 4'he;
    end
    e_kind = (w[27:24] == 4'd0) ? 2'd0 : (w[27:24] == 4'd1) ? 2'd1 : 2'd2;
    ev = {e_rdy, iswr, iswr ? {m_cls, e_off, e_data} : 54'b0,
          e_rv, e_rv ? {w[27:0], 4'b0} : 32'b0,
          e_gv, e_gv ? {m_gat, w} : 60'b0,
          e_xv, e_xv ? {e_kind, w[7:0]} : 10'b0};
    av = {in_ready, wr_valid, wr_valid ? {wr_class, wr_offset, wr_data} : 54'b0,
          rst_valid, rst_valid ? rst_addr : 32'b0,
          gat_valid, gat_valid ? {gat_offset, gat_insert, gat_type, gat_count, gat_addr} : 60'b0,
          ext_valid, ext_valid ? {ext_kind, ext_index} : 10'b0};
    if (tag_in != "") tag = tag_in;
    else if (iswr && !rdy) tag = "R11";
    else tag = op_tag(m_pay ? m_op : w[31:28]);
    check(tag, av, ev);
    if (e_rdy) begin
      if (!m_pay) begin
        m_op = w[31:28]; m_off = w[27:16]; m_mask = '0; m_rem = 0;
        case (w[31:28])
          4'h0: begin m_cls = w[15:6]; m_mask = {10'b0, w[5:0]}; m_rem = $countones(w[5:0]); end
          4'h1, 4'h2: m_rem = int'(w[15:0]);
          4'h3: begin m_mask = w[15:0]; m_rem = $countones(w[15:0]); end
          4'h6: begin m_rem = 1; m_gat = w[27:0]; end
          default: m_rem = 0;
        endcase
        m_pay = (m_rem != 0);
      end else begin
        m_rem--;
        m_pay = (m_rem != 0);
        if (m_op == 4'h1) m_off = m_off + 12'd1;
        m_mask = m_mask & (m_mask - 16'd1);
      end
    end
  endtask

  function automatic logic [31:0] rand_hdr();
    logic [3:0] ops [10] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'he, 4'h7, 4'hf};
    logic [31:0] w;
    w = $urandom;
    w[31:28] = ops[$urandom_range(0, 9)];
    if (w[31:28] == 4'h1 || w[31:28] == 4'h2) w[15:0] = 16'($urandom_range(0, 5));
    if (w[31:28] == 4'he) w[27:24] = 4'($urandom_range(0, 3));
    return w;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    // R12 reset state: idle, ready, no pulses
    check("R12", {in_ready, wr_valid, rst_valid, gat_valid, ext_valid}, {1'b1, 4'b0});
    drive(32'h4123_0abc, 1'b1, "R12");
    // R2 zero mask: class changes, no payload
    drive({4'h0, 12'h010, 10'h2aa, 6'h00}, 1'b1, "R2");
    drive(32'h4005_1234, 1'b1, "R2");
    // R2 sparse mask
    drive({4'h0, 12'h100, 10'h155, 6'b101001}, 1'b1, "R2");
    drive(32'h1111_1111, 1'b1, "R2");
    drive(32'h2222_2222, 1'b1, "R2");
    drive(32'h3333_3333, 1'b1, "R2");
    // R10 zero-count incr, next word is header
    drive(32'h1050_0000, 1'b1, "R10");
    drive(32'h4050_00ff, 1'b1, "R10");
    // R5 wrapping masked write
    drive(32'h3fff_8001, 1'b1, "R5");
    drive(32'haaaa_0001, 1'b1, "R5");
    drive(32'haaaa_0002, 1'b1, "R5");
    // R1 unknown opcode with count-like bits
    drive(32'h7000_0003, 1'b1, "R1");
    drive(32'h4001_0001, 1'b1, "R1");
    // R9 extend kinds
    drive(32'he000_0011, 1'b1, "R9");
    drive(32'he100_0022, 1'b1, "R9");
    drive(32'he500_0033, 1'b1, "R9");
    // R7 restart
    drive(32'h5abc_def1, 1'b1, "R7");
    // R8 gather
    drive(32'h6123_c005, 1'b1, "R8");
    drive(32'hdead_beef, 1'b1, "R8");
    // R11 stalls on imm and incr payload
    drive(32'h4077_0007, 1'b0, "R11");
    drive(32'h4077_0007, 1'b1, "R11");
    drive(32'h1200_0002, 1'b0, "R3");
    drive(32'h0000_00aa, 1'b0, "R11");
    drive(32'h0000_00aa, 1'b1, "R3");
    drive(32'h0000_00bb, 1'b1, "R3");
    // R4 non-incrementing
    drive(32'h2300_0002, 1'b1, "R4");
    drive(32'h0000_0001, 1'b1, "R4");
    drive(32'h0000_0002, 1'b1, "R4");
    // random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      w = m_pay ? $urandom : rand_hdr();
      drive(w, ($urandom_range(0, 3) != 0), "");
    end
    @(negedge clk); in_valid = 1'b0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule